// File: doc/BRIEF.md
# Neighbour-Copy Tag Recovery for a Set-Associative Cache

This block holds the tag store of a set-associative cache and guards it against single-bit upsets without an error-correcting code. Every stored tag carries an even parity bit and two flags. One flag says whether the line in the same way of the previous set holds an identical tag. The other says the same for the next set. Set indices wrap at both ends. The flags are computed when a line is written. When a neighbour line is rewritten, the flag that faces it is updated in the same cycle.

A lookup reads every way of the addressed set. If a valid line fails its parity check, the block rewrites that line's tag from a flagged, healthy neighbour and recomputes the parity. It then reports a corrected error and makes the hit/miss decision one cycle later. If no flagged neighbour exists, the block reports an uncorrectable error and drops the line, so that line can only miss. A fill port writes new tags. A lookup port returns hit and way. A fault-injection port flips one stored bit so that the recovery paths can be exercised.

Top module: `neighbor_tag_guard`

## Requirements
- R1: After reset every line is invalid. `lookupReady` is 1, and `lookupDone`, `corrected` and `uncorrectable` are 0. Any lookup misses.
- R2: A lookup accepted at clock edge k (`lookupValid` high while `lookupReady` is 1) raises `lookupDone` for one cycle after edge k+1 when no stored bit is in error. `lookupHit` is 1 and `lookupWay` names the lowest way whose valid line holds the requested tag.
- R3: A lookup whose tag matches no valid, parity-clean line of the set reports `lookupHit` = 0 and `lookupWay` = 0.
- R4: Each stored tag has an even parity bit equal to the XOR of the tag bits. A flip of any single tag bit or of the parity bit (flip index TAG_W) is detected on the next lookup of that set.
- R5: When a line is written, its previous-set flag is set only if the same way of set index−1 (wrapping) is valid, parity-clean and holds an identical tag. Its next-set flag follows the same rule for index+1. The facing flag of each neighbour is set to the same value.
- R6: A lookup that finds a parity error in a line flagged identical to a healthy neighbour rewrites the tag from that neighbour. The previous-set neighbour is used first, then the next-set neighbour. `corrected` pulses for one cycle, and `lookupDone` comes one cycle later than in R2, with a hit on the restored tag.
- R7: A parity error with no usable flagged neighbour pulses `uncorrectable` for one cycle and invalidates the line. The lookup completes one cycle later than in R2 with a miss for that line. Later lookups of that set miss with no status pulse.
- R8: Rewriting a neighbour with a different tag clears the flags that pointed at it, so a later error in the line it protected is uncorrectable.
- R9: Set 0 and set SETS−1 are neighbours of each other in both directions.
- R10: While a lookup is in flight, `lookupReady` is 0. A `lookupValid` presented then is ignored and produces no second `lookupDone`.
- R11: A fill presented in a lookup's decision cycle takes the write path. The decision moves one cycle later and reflects the filled line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| fillValid | input | 1 | Write a new tag this cycle |
| fillSet | input | log2(SETS) | Set index of the fill |
| fillWay | input | log2(WAYS) | Way of the fill |
| fillTag | input | TAG_W | Tag value written |
| lookupValid | input | 1 | Start a lookup (taken when lookupReady is 1) |
| lookupSet | input | log2(SETS) | Set index searched |
| lookupTag | input | TAG_W | Tag searched for |
| lookupReady | output | 1 | No lookup in flight |
| lookupDone | output | 1 | One-cycle pulse: result valid |
| lookupHit | output | 1 | Result: tag found |
| lookupWay | output | log2(WAYS) | Result: matching way (0 on miss) |
| corrected | output | 1 | One-cycle pulse: a tag was restored from a neighbour |
| uncorrectable | output | 1 | One-cycle pulse: a corrupted line was dropped |
| flipEn | input | 1 | Invert one stored bit this cycle |
| flipSet | input | log2(SETS) | Set of the bit to invert |
| flipWay | input | log2(WAYS) | Way of the bit to invert |
| flipBit | input | log2(TAG_W+1) | Bit to invert: 0..TAG_W−1 tag, TAG_W parity |

## Verification
The bench builds the block with eight sets, two ways and 8-bit tags. With eight sets there is room for chains of identical tags across sets 4–5, 6–7 and the wrap pair 7–0, while other sets keep empty neighbours for the uncorrectable path. With two ways, a line in one way can sit beside an unrelated line in the other, so the lowest-way hit choice and the per-way flags are both observable. Single-bit flips go to tag bits and to the parity bit, and a fill lands in the decision cycle of a lookup.

// File: rtl/tag_guard_pkg.sv
package tag_guard_pkg;

  // Source of the tag written into a line.
  typedef enum logic [1:0] {
    SRC_FILL = 2'd0,
    SRC_LO   = 2'd1,
    SRC_HI   = 2'd2,
    SRC_DROP = 2'd3
  } wrSrc_e;

  // Control-to-datapath strobes.
  typedef struct packed {
    logic   wrEn;
    wrSrc_e wrSrc;
  } ctlStrobe_t;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_CHECK = 1'b1
  } ctlState_e;

endpackage

// File: rtl/tag_guard_dp.sv
module tag_guard_dp
  import tag_guard_pkg::*;
#(
  parameter int SETS  = 8,
  parameter int WAYS  = 2,
  parameter int TAG_W = 8,
  localparam int SET_W  = $clog2(SETS),
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int FLIP_W = $clog2(TAG_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [SET_W-1:0]  wrSet,
  input  logic [WAY_W-1:0]  wrWay,
  input  logic [TAG_W-1:0]  fillTag,
  input  logic [SET_W-1:0]  lookSet,
  input  logic [TAG_W-1:0]  lookTag,
  input  logic              flipEn,
  input  logic [SET_W-1:0]  flipSet,
  input  logic [WAY_W-1:0]  flipWay,
  input  logic [FLIP_W-1:0] flipBit,
  output logic [WAYS-1:0]   errVec,
  output logic [WAYS-1:0]   hitVec,
  output logic [WAYS-1:0]   canLoVec,
  output logic [WAYS-1:0]   canHiVec
);

  typedef struct packed {
    logic             valid;
    logic             par;
    logic             sameLo;
    logic             sameHi;
    logic [TAG_W-1:0] tag;
  } line_t;

  line_t mem [SETS][WAYS];

  function automatic logic [SET_W-1:0] prevSet(input logic [SET_W-1:0] s);
    return (s == '0) ? SET_W'(SETS - 1) : s - 1'b1;
  endfunction

  function automatic logic [SET_W-1:0] nextSet(input logic [SET_W-1:0] s);
    return (s == SET_W'(SETS - 1)) ? '0 : s + 1'b1;
  endfunction

  function automatic logic lineOk(input line_t l);
    return l.valid && ((^l.tag) == l.par);
  endfunction

  // Lookup-side view of the addressed set and its neighbours
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      line_t cur, lo, hi;
      cur = mem[lookSet][w];
      lo  = mem[prevSet(lookSet)][w];
      hi  = mem[nextSet(lookSet)][w];
      errVec[w]   = cur.valid && ((^cur.tag) != cur.par);
      hitVec[w]   = lineOk(cur) && (cur.tag == lookTag);
      canLoVec[w] = cur.sameLo && lineOk(lo);
      canHiVec[w] = cur.sameHi && lineOk(hi);
    end
  end

  // Write side: new line contents and neighbour comparison
  logic [SET_W-1:0] wrLoSet, wrHiSet;
  line_t            wLo, wHi;
  logic [TAG_W-1:0] newTag;
  logic             newValid, eqLo, eqHi;
  logic [TAG_W:0]   flipMask;

  assign wrLoSet  = prevSet(wrSet);
  assign wrHiSet  = nextSet(wrSet);
  assign wLo      = mem[wrLoSet][wrWay];
  assign wHi      = mem[wrHiSet][wrWay];
  assign flipMask = (TAG_W + 1)'(1) << flipBit;

  always_comb begin
    unique case (strobe.wrSrc)
      SRC_FILL: newTag = fillTag;
      SRC_LO:   newTag = wLo.tag;
      SRC_HI:   newTag = wHi.tag;
      default:  newTag = '0;
    endcase
    newValid = (strobe.wrSrc != SRC_DROP);
    eqLo     = newValid && lineOk(wLo) && (wLo.tag == newTag);
    eqHi     = newValid && lineOk(wHi) && (wHi.tag == newTag);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          mem[s][w] <= '0;
    end else begin
      if (flipEn) begin
        mem[flipSet][flipWay].tag <= mem[flipSet][flipWay].tag ^ flipMask[TAG_W-1:0];
        mem[flipSet][flipWay].par <= mem[flipSet][flipWay].par ^ flipMask[TAG_W];
      end
      if (strobe.wrEn) begin
        mem[wrSet][wrWay]          <= '{valid: newValid, par: ^newTag,
                                        sameLo: eqLo, sameHi: eqHi, tag: newTag};
        mem[wrLoSet][wrWay].sameHi <= eqLo;
        mem[wrHiSet][wrWay].sameLo <= eqHi;
      end
    end
  end

  // Assertion support: remember the last clean write
  logic             lastWr;
  logic [SET_W-1:0] lastSet;
  logic [WAY_W-1:0] lastWay;
  line_t            lastLine;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastWr  <= 1'b0;
      lastSet <= '0;
      lastWay <= '0;
    end else begin
      lastWr  <= strobe.wrEn && (strobe.wrSrc != SRC_DROP) &&
                 !(flipEn && (flipSet == wrSet) && (flipWay == wrWay));
      lastSet <= wrSet;
      lastWay <= wrWay;
    end
  end
  assign lastLine = mem[lastSet][lastWay];

  // R4: a written line comes out valid with matching parity
  assert_fresh_parity_R4: assert property (@(posedge clk) disable iff (!rstN)
    lastWr |-> (lastLine.valid && ((^lastLine.tag) == lastLine.par)));

  // R5: facing flags of adjacent sets always agree
  for (genvar s = 0; s < SETS; s++) begin : gPair
    for (genvar w = 0; w < WAYS; w++) begin : gWay
      assert_flag_pair_R5: assert property (@(posedge clk) disable iff (!rstN)
        mem[s][w].sameHi == mem[(s + 1) % SETS][w].sameLo);
    end
  end

endmodule

// File: rtl/tag_guard_ctl.sv
module tag_guard_ctl
  import tag_guard_pkg::*;
#(
  parameter int SETS  = 8,
  parameter int WAYS  = 2,
  parameter int TAG_W = 8,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fillValid,
  input  logic [SET_W-1:0] fillSet,
  input  logic [WAY_W-1:0] fillWay,
  input  logic             lookupValid,
  input  logic [SET_W-1:0] lookupSet,
  input  logic [TAG_W-1:0] lookupTag,
  input  logic [WAYS-1:0]  errVec,
  input  logic [WAYS-1:0]  hitVec,
  input  logic [WAYS-1:0]  canLoVec,
  input  logic [WAYS-1:0]  canHiVec,
  output ctlStrobe_t       strobe,
  output logic [SET_W-1:0] wrSet,
  output logic [WAY_W-1:0] wrWay,
  output logic [SET_W-1:0] lookSet,
  output logic [TAG_W-1:0] lookTag,
  output logic             lookupReady,
  output logic             lookupDone,
  output logic             lookupHit,
  output logic [WAY_W-1:0] lookupWay,
  output logic             corrected,
  output logic             uncorrectable
);

  ctlState_e        state;
  logic [SET_W-1:0] reqSet;
  logic [TAG_W-1:0] reqTag;
  logic [WAY_W-1:0] errWay, hitWay;
  logic             anyErr, anyHit, canFix;

  assign lookSet     = reqSet;
  assign lookTag     = reqTag;
  assign lookupReady = (state == ST_IDLE);
  assign anyErr      = |errVec;
  assign anyHit      = |hitVec;
  assign canFix      = canLoVec[errWay] || canHiVec[errWay];

  // Lowest-numbered way with an error / with a hit
  always_comb begin
    errWay = '0;
    hitWay = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (errVec[w]) errWay = WAY_W'(w);
      if (hitVec[w]) hitWay = WAY_W'(w);
    end
  end

  // Write-port arbitration: fill first, then repair or drop
  always_comb begin
    strobe.wrEn  = 1'b0;
    strobe.wrSrc = SRC_FILL;
    wrSet        = fillSet;
    wrWay        = fillWay;
    if (fillValid) begin
      strobe.wrEn = 1'b1;
    end else if (state == ST_CHECK && anyErr) begin
      strobe.wrEn  = 1'b1;
      wrSet        = reqSet;
      wrWay        = errWay;
      strobe.wrSrc = canLoVec[errWay] ? SRC_LO :
                     canHiVec[errWay] ? SRC_HI : SRC_DROP;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state         <= ST_IDLE;
      reqSet        <= '0;
      reqTag        <= '0;
      lookupDone    <= 1'b0;
      lookupHit     <= 1'b0;
      lookupWay     <= '0;
      corrected     <= 1'b0;
      uncorrectable <= 1'b0;
    end else begin
      lookupDone    <= 1'b0;
      corrected     <= 1'b0;
      uncorrectable <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (lookupValid) begin
            reqSet <= lookupSet;
            reqTag <= lookupTag;
            state  <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (fillValid) begin
            state <= ST_CHECK;
          end else if (anyErr) begin
            corrected     <= canFix;
            uncorrectable <= !canFix;
          end else begin
            lookupDone <= 1'b1;
            lookupHit  <= anyHit;
            lookupWay  <= anyHit ? hitWay : '0;
            state      <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: the two error reports never coincide
  assert_status_excl_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(corrected && uncorrectable));

  // R6/R7: a repair cycle is never also the result cycle
  assert_repair_delays_R7: assert property (@(posedge clk) disable iff (!rstN)
    (corrected || uncorrectable) |-> !lookupDone);

  // R10: an accepted lookup makes the port busy
  assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (!rstN)
    (lookupValid && lookupReady) |=> !lookupReady);

  // R2: a result follows a busy cycle
  assert_done_after_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    lookupDone |-> !$past(lookupReady));

endmodule

// File: rtl/neighbor_tag_guard.sv
module neighbor_tag_guard
  import tag_guard_pkg::*;
#(
  parameter int SETS  = 8,
  parameter int WAYS  = 2,
  parameter int TAG_W = 8,
  localparam int SET_W  = $clog2(SETS),
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int FLIP_W = $clog2(TAG_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fillValid,
  input  logic [SET_W-1:0]  fillSet,
  input  logic [WAY_W-1:0]  fillWay,
  input  logic [TAG_W-1:0]  fillTag,
  input  logic              lookupValid,
  input  logic [SET_W-1:0]  lookupSet,
  input  logic [TAG_W-1:0]  lookupTag,
  output logic              lookupReady,
  output logic              lookupDone,
  output logic              lookupHit,
  output logic [WAY_W-1:0]  lookupWay,
  output logic              corrected,
  output logic              uncorrectable,
  input  logic              flipEn,
  input  logic [SET_W-1:0]  flipSet,
  input  logic [WAY_W-1:0]  flipWay,
  input  logic [FLIP_W-1:0] flipBit
);

  ctlStrobe_t       strobe;
  logic [SET_W-1:0] wrSet, lookSet;
  logic [WAY_W-1:0] wrWay;
  logic [TAG_W-1:0] lookTag;
  logic [WAYS-1:0]  errVec, hitVec, canLoVec, canHiVec;

  tag_guard_ctl #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) uCtl (
    .clk(clk), .rstN(rstN),
    .fillValid(fillValid), .fillSet(fillSet), .fillWay(fillWay),
    .lookupValid(lookupValid), .lookupSet(lookupSet), .lookupTag(lookupTag),
    .errVec(errVec), .hitVec(hitVec), .canLoVec(canLoVec), .canHiVec(canHiVec),
    .strobe(strobe), .wrSet(wrSet), .wrWay(wrWay),
    .lookSet(lookSet), .lookTag(lookTag),
    .lookupReady(lookupReady), .lookupDone(lookupDone),
    .lookupHit(lookupHit), .lookupWay(lookupWay),
    .corrected(corrected), .uncorrectable(uncorrectable)
  );

  tag_guard_dp #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) uDp (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .wrSet(wrSet), .wrWay(wrWay), .fillTag(fillTag),
    .lookSet(lookSet), .lookTag(lookTag),
    .flipEn(flipEn), .flipSet(flipSet), .flipWay(flipWay), .flipBit(flipBit),
    .errVec(errVec), .hitVec(hitVec), .canLoVec(canLoVec), .canHiVec(canHiVec)
  );

endmodule

// File: tb/sim_neighbor_tag_guard.sv
module sim_neighbor_tag_guard;

  localparam int SETS = 8, WAYS = 2, TAG_W = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       fillValid = 1'b0;
  logic [2:0] fillSet = '0;
  logic       fillWay = '0;
  logic [7:0] fillTag = '0;
  logic       lookupValid = 1'b0;
  logic [2:0] lookupSet = '0;
  logic [7:0] lookupTag = '0;
  logic       lookupReady, lookupDone, lookupHit, lookupWay;
  logic       corrected, uncorrectable;
  logic       flipEn = 1'b0;
  logic [2:0] flipSet = '0;
  logic       flipWay = '0;
  logic [3:0] flipBit = '0;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  neighbor_tag_guard #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u0 (
    .clk(clk), .rstN(rstN),
    .fillValid(fillValid), .fillSet(fillSet), .fillWay(fillWay), .fillTag(fillTag),
    .lookupValid(lookupValid), .lookupSet(lookupSet), .lookupTag(lookupTag),
    .lookupReady(lookupReady), .lookupDone(lookupDone),
    .lookupHit(lookupHit), .lookupWay(lookupWay),
    .corrected(corrected), .uncorrectable(uncorrectable),
    .flipEn(flipEn), .flipSet(flipSet), .flipWay(flipWay), .flipBit(flipBit)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<=20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic doFill(int s, int w, int t);
    @(negedge clk);
    fillValid = 1'b1; fillSet = 3'(s); fillWay = 1'(w); fillTag = 8'(t);
    @(posedge clk);
    @(negedge clk);
    fillValid = 1'b0;
  endtask

  task automatic doFlip(int s, int w, int b);
    @(negedge clk);
    flipEn = 1'b1; flipSet = 3'(s); flipWay = 1'(w); flipBit = 4'(b);
    @(posedge clk);
    @(negedge clk);
    flipEn = 1'b0;
  endtask

  // Latency counts negedges after the accepting edge: 2 clean, 3 with repair.
  task automatic runLookup(string req, int s, int t, int expHit, int expWay,
                           int expLat, int expCorr, int expUnc);
    int lat;
    int sawC;
    int sawU;
    @(negedge clk);
    lookupValid = 1'b1; lookupSet = 3'(s); lookupTag = 8'(t);
    @(posedge clk);
    @(negedge clk);
    lookupValid = 1'b0;
    lat = 1;
    sawC = int'(corrected);
    sawU = int'(uncorrectable);
    while (!lookupDone && lat < 8) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
      sawC += int'(corrected);
      sawU += int'(uncorrectable);
    end
    check(req, "latency", lat, expLat);
    check(req, "hit", int'(lookupHit), expHit);
    check(req, "way", int'(lookupWay), expWay);
    check(req, "corrected pulses", sawC, expCorr);
    check(req, "uncorrectable pulses", sawU, expUnc);
  endtask

  task automatic testReset();
    check("R1", "ready", int'(lookupReady), 1);
    check("R1", "done", int'(lookupDone), 0);
    check("R1", "corrected", int'(corrected), 0);
    check("R1", "uncorrectable", int'(uncorrectable), 0);
    runLookup("R1", 3, 8'h00, 0, 0, 2, 0, 0);
  endtask

  task automatic testHitMiss();
    doFill(2, 1, 8'h5A);
    runLookup("R2", 2, 8'h5A, 1, 1, 2, 0, 0);
    runLookup("R3", 2, 8'h5B, 0, 0, 2, 0, 0);
  endtask

  task automatic testRepairLo();
    doFill(4, 0, 8'h33);
    doFill(5, 0, 8'h33);
    doFlip(5, 0, 2);
    runLookup("R6", 5, 8'h33, 1, 0, 3, 1, 0);
    runLookup("R5", 5, 8'h33, 1, 0, 2, 0, 0);
  endtask

  task automatic testRepairHi();
    doFill(6, 1, 8'h77);
    doFill(7, 1, 8'h77);
    doFlip(6, 1, 0);
    runLookup("R6", 6, 8'h77, 1, 1, 3, 1, 0);
  endtask

  task automatic testParityBit();
    doFlip(5, 0, TAG_W);
    runLookup("R4", 5, 8'h33, 1, 0, 3, 1, 0);
  endtask

  task automatic testUncorrectable();
    doFill(1, 0, 8'h11);
    doFlip(1, 0, 7);
    runLookup("R7", 1, 8'h11, 0, 0, 3, 0, 1);
    runLookup("R7", 1, 8'h11, 0, 0, 2, 0, 0);
  endtask

  task automatic testReplaceClears();
    doFill(4, 0, 8'h44);
    doFlip(5, 0, 1);
    runLookup("R8", 5, 8'h33, 0, 0, 3, 0, 1);
  endtask

  task automatic testWrap();
    doFill(7, 0, 8'hC3);
    doFill(0, 0, 8'hC3);
    doFlip(0, 0, 4);
    runLookup("R9", 0, 8'hC3, 1, 0, 3, 1, 0);
    doFlip(7, 0, 3);
    runLookup("R9", 7, 8'hC3, 1, 0, 3, 1, 0);
  endtask

  task automatic testBusy();
    @(negedge clk);
    lookupValid = 1'b1; lookupSet = 3'd2; lookupTag = 8'h5A;
    @(posedge clk);
    @(negedge clk);
    check("R10", "ready while busy", int'(lookupReady), 0);
    lookupTag = 8'hEE;
    @(posedge clk);
    @(negedge clk);
    lookupValid = 1'b0;
    check("R10", "done", int'(lookupDone), 1);
    check("R10", "hit of first request", int'(lookupHit), 1);
    check("R10", "way of first request", int'(lookupWay), 1);
    @(posedge clk);
    @(negedge clk);
    check("R10", "no second done", int'(lookupDone), 0);
  endtask

  task automatic testFillInDecision();
    @(negedge clk);
    lookupValid = 1'b1; lookupSet = 3'd3; lookupTag = 8'h3C;
    @(posedge clk);
    @(negedge clk);
    lookupValid = 1'b0;
    fillValid = 1'b1; fillSet = 3'd3; fillWay = 1'b1; fillTag = 8'h3C;
    @(posedge clk);
    @(negedge clk);
    fillValid = 1'b0;
    check("R11", "done held back", int'(lookupDone), 0);
    @(posedge clk);
    @(negedge clk);
    check("R11", "done", int'(lookupDone), 1);
    check("R11", "hit on filled tag", int'(lookupHit), 1);
    check("R11", "way", int'(lookupWay), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testHitMiss();
    testRepairLo();
    testRepairHi();
    testParityBit();
    testUncorrectable();
    testReplaceClears();
    testWrap();
    testBusy();
    testFillInDecision();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule